// File: doc/BRIEF.md
# Sum-of-Products Logic Array with Fixed Output Grouping

This block is a two-level logic array. A programmable AND stage builds product terms from the array inputs. A hard-wired OR stage then merges those terms into output sums. Every product-term line can use the true copy and the inverted copy of every input, and one stored bit per crossing decides whether that literal joins the product. The OR stage has no configuration. Each output owns a fixed, disjoint run of consecutive product terms. A function that needs more terms than its run provides cannot be placed on that output.

The map is written serially. One bit enters per clock while the load enable is high. Once a complete map is held, the outputs follow the inputs combinationally. A readback pointer walks the stored map bit by bit and leaves the evaluated outputs untouched. Polarity control, output registers and pin direction are handled by an output cell outside this block.

Top module: `sop_array`

## Requirements
- R1: The map has 2·NUM_IN·P bits, where P = NUM_OUT·TERMS_PER_OUT. The bit for term t and input i is at index t·2·NUM_IN + 2·i for the true literal, and at the next index up for the complement literal. Bits enter MSB-first, one per rising clock edge while load_en_i is high, so the first bit shifted in ends at the top index.
- R2: A product term is the AND of its connected literals. A true literal is in_i[i] and a complement literal is ~in_i[i].
- R3: A product term with no connected literal is 0.
- R4: A product term that connects both the true and the complement literal of the same input is 0.
- R5: Output o is the OR of terms o·TERMS_PER_OUT through o·TERMS_PER_OUT+TERMS_PER_OUT-1. Terms outside that run have no effect on it.
- R6: sum_o is all zeros while load_en_i is high. After a load session of at least the full map width, sum_o becomes valid on the first rising edge at which load_en_i is low.
- R7: A load session shorter than the map width leaves sum_o at all zeros, even if a valid map was held before.
- R8: rd_bit_o shows the map bit at the readback pointer. The pointer starts at the top index after reset and after each load. Each clock edge with rd_en_i high and load_en_i low moves the pointer to the next lower index, and it wraps from 0 back to the top. Readback changes neither the map nor sum_o.
- R9: After reset the map is all zeros, sum_o is zero and rd_bit_o is 0.
- R10: Once a valid map is held, sum_o responds to in_i with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_en_i | input | 1 | Shifts cfg_bit_i into the map on each edge while high |
| cfg_bit_i | input | 1 | Serial map bit, MSB-first |
| rd_en_i | input | 1 | Moves the readback pointer one bit lower |
| rd_bit_o | output | 1 | Map bit at the readback pointer |
| in_i | input | NUM_IN | Array inputs |
| sum_o | output | NUM_OUT | Masked sum outputs |

## Verification
The sum outputs and the readback bit are combinational. The bench therefore changes in_i at a falling edge and samples sum_o 1 ns later, in the same half cycle. The map and the load state are registered. sum_o is expected to be zero in the half cycle right after load_en_i falls, and to become valid only after the next rising edge. The bench also checks zeros at every falling edge during a load. During readback, the bench reads rd_bit_o before each rising edge that advances the pointer. It checks the wrapped bit after the last edge and confirms that sum_o holds a fixed value throughout.

// File: rtl/sop_pkg.sv
package sop_pkg;
  function automatic int map_width(input int n_in, input int n_terms);
    return 2 * n_in * n_terms;
  endfunction
endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
  parameter int CFG_W = 36
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_en_i,
  input  logic             cfg_bit_i,
  input  logic             rd_en_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             valid_o,
  output logic             rd_bit_o
);
  localparam int CNT_W = $clog2(CFG_W + 1);
  localparam int PTR_W = $clog2(CFG_W);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CFG_W);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(CFG_W - 1);

  logic [CFG_W-1:0] cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] ptr_q;
  logic             valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      cnt_q   <= '0;
      ptr_q   <= LAST;
      valid_q <= 1'b0;
    end else if (load_en_i) begin
      cfg_q   <= {cfg_q[CFG_W-2:0], cfg_bit_i};
      valid_q <= 1'b0;
      ptr_q   <= LAST;
      if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
      if (cnt_q == FULL) valid_q <= 1'b1;
      if (rd_en_i) ptr_q <= (ptr_q == '0) ? LAST : ptr_q - 1'b1;
    end
  end

  assign cfg_o    = cfg_q;
  assign valid_o  = valid_q;
  assign rd_bit_o = cfg_q[ptr_q];

  // readback must not disturb the map
  p_readback_keeps_map_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !load_en_i) |=> $stable(cfg_q));
  p_readback_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !load_en_i && ptr_q == '0) |=> (ptr_q == LAST));
  p_short_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_en_i && cnt_q != FULL && !valid_q) |=> !valid_q);
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
  parameter int NUM_IN  = 3,
  parameter int N_TERMS = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_IN-1:0]             in_i,
  input  logic [2*NUM_IN*N_TERMS-1:0]   cfg_i,
  output logic [N_TERMS-1:0]            prod_o
);
  localparam int LIT_W = 2 * NUM_IN;

  logic [LIT_W-1:0] lits;

  always_comb begin
    for (int i = 0; i < NUM_IN; i++) begin
      lits[2*i]   = in_i[i];
      lits[2*i+1] = ~in_i[i];
    end
  end

  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    logic [LIT_W-1:0] used;
    logic             clash;
    assign used = cfg_i[t*LIT_W +: LIT_W];
    // empty term is forced low so unused lines never assert a sum
    assign prod_o[t] = (|used) & (&(lits | ~used));

    always_comb begin
      clash = 1'b0;
      for (int i = 0; i < NUM_IN; i++) clash |= used[2*i] & used[2*i+1];
    end

    p_empty_term_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (used == '0) |-> !prod_o[t]);
    p_conflict_term_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clash |-> !prod_o[t]);
  end
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
  parameter int NUM_OUT       = 2,
  parameter int TERMS_PER_OUT = 3
) (
  input  logic [NUM_OUT*TERMS_PER_OUT-1:0] prod_i,
  output logic [NUM_OUT-1:0]               sum_o
);
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_sum
    assign sum_o[o] = |prod_i[o*TERMS_PER_OUT +: TERMS_PER_OUT];
  end
endmodule

// File: rtl/sop_array.sv
module sop_array #(
  parameter int NUM_IN        = 16,
  parameter int NUM_OUT       = 8,
  parameter int TERMS_PER_OUT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_en_i,
  input  logic               cfg_bit_i,
  input  logic               rd_en_i,
  output logic               rd_bit_o,
  input  logic [NUM_IN-1:0]  in_i,
  output logic [NUM_OUT-1:0] sum_o
);
  localparam int N_TERMS = NUM_OUT * TERMS_PER_OUT;
  localparam int CFG_W   = sop_pkg::map_width(NUM_IN, N_TERMS);

  logic [CFG_W-1:0]   cfg;
  logic               valid;
  logic [N_TERMS-1:0] prod;
  logic [NUM_OUT-1:0] raw_sum;

  sop_cfg_store #(.CFG_W(CFG_W)) u_store (
    .clk_i, .rst_ni, .load_en_i, .cfg_bit_i, .rd_en_i,
    .cfg_o(cfg), .valid_o(valid), .rd_bit_o
  );

  sop_and_plane #(.NUM_IN(NUM_IN), .N_TERMS(N_TERMS)) u_and (
    .clk_i, .rst_ni, .in_i, .cfg_i(cfg), .prod_o(prod)
  );

  sop_or_plane #(.NUM_OUT(NUM_OUT), .TERMS_PER_OUT(TERMS_PER_OUT)) u_or (
    .prod_i(prod), .sum_o(raw_sum)
  );

  assign sum_o = (valid && !load_en_i) ? raw_sum : '0;

  p_mask_during_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i |-> (sum_o == '0));
  p_sum_needs_term_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prod == '0) |-> (sum_o == '0));
endmodule

// File: tb/sop_array_bench.sv
module sop_array_bench;
  localparam int NI = 3;
  localparam int NO = 2;
  localparam int K  = 3;
  localparam int NT = NO * K;
  localparam int LW = 2 * NI;
  localparam int CW = LW * NT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_en = 1'b0;
  logic cfg_bit = 1'b0;
  logic rd_en = 1'b0;
  logic rd_bit;
  logic [NI-1:0] in_v = '0;
  logic [NO-1:0] sum;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sop_array #(.NUM_IN(NI), .NUM_OUT(NO), .TERMS_PER_OUT(K)) u_sop_array (
    .clk_i(clk), .rst_ni(rst_n), .load_en_i(load_en), .cfg_bit_i(cfg_bit),
    .rd_en_i(rd_en), .rd_bit_o(rd_bit), .in_i(in_v), .sum_o(sum)
  );

  function automatic logic [NO-1:0] model(input logic [CW-1:0] c, input logic [NI-1:0] x);
    logic [NO-1:0] s = '0;
    for (int o = 0; o < NO; o++) begin
      for (int k = 0; k < K; k++) begin
        int t = o * K + k;
        bit any = 1'b0;
        bit p = 1'b1;
        for (int i = 0; i < NI; i++) begin
          if (c[t*LW + 2*i])   begin any = 1'b1; if (!x[i]) p = 1'b0; end
          if (c[t*LW + 2*i+1]) begin any = 1'b1; if (x[i])  p = 1'b0; end
        end
        if (any && p) s[o] = 1'b1;
      end
    end
    return s;
  endfunction

  function automatic logic [CW-1:0] add_lit(input logic [CW-1:0] c, input int t, input int i, input bit neg);
    c[t*LW + 2*i + (neg ? 1 : 0)] = 1'b1;
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [CW-1:0] c, input int nbits, input bit mid_chk);
    for (int k = 0; k < nbits; k++) begin
      @(negedge clk);
      load_en = 1'b1;
      cfg_bit = c[CW-1-k];
      if (mid_chk && k > 0) begin
        #1 check(sum == '0, "R6 masked during load", sum, 0);
      end
    end
    @(negedge clk);
    load_en = 1'b0;
    cfg_bit = 1'b0;
    if (mid_chk) begin
      #1 check(sum == '0, "R6 not valid before next edge", sum, 0);
    end
    @(negedge clk);
  endtask

  task automatic sweep(input logic [CW-1:0] c, input string req);
    for (int v = 0; v < (1 << NI); v++) begin
      @(negedge clk);
      in_v = NI'(v);
      #1 check(sum == model(c, NI'(v)), req, sum, model(c, NI'(v)));
    end
  endtask

  initial begin
    logic [CW-1:0] cfg_a;
    logic [CW-1:0] cfg_b;
    logic [CW-1:0] cfg_r;
    logic [31:0]   lfsr;

    // R9 reset state
    #5;
    check(sum == '0, "R9 reset sum", sum, 0);
    check(rd_bit == 1'b0, "R9 reset readback", rd_bit, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int v = 0; v < (1 << NI); v++) begin
      @(negedge clk);
      in_v = NI'(v);
      #1 check(sum == '0, "R9 no map after reset", sum, 0);
    end

    // R1 bit order: only term 0 true literal of input 0 -> sum[0] = in[0]
    cfg_b = add_lit('0, 0, 0, 1'b0);
    load(cfg_b, CW, 1'b1);
    for (int v = 0; v < (1 << NI); v++) begin
      @(negedge clk);
      in_v = NI'(v);
      #1 check(sum == {1'b0, in_v[0]}, "R1 order single literal", sum, {1'b0, in_v[0]});
    end

    // R3 all-empty map loaded
    load('0, CW, 1'b0);
    sweep('0, "R3 empty terms");

    // hand map: t0=in0&~in1, t1=in2, t2 empty | t3=~in0&~in2, t4=in0&in1&~in1, t5 empty
    cfg_a = '0;
    cfg_a = add_lit(cfg_a, 0, 0, 1'b0);
    cfg_a = add_lit(cfg_a, 0, 1, 1'b1);
    cfg_a = add_lit(cfg_a, 1, 2, 1'b0);
    cfg_a = add_lit(cfg_a, 3, 0, 1'b1);
    cfg_a = add_lit(cfg_a, 3, 2, 1'b1);
    cfg_a = add_lit(cfg_a, 4, 0, 1'b0);
    cfg_a = add_lit(cfg_a, 4, 1, 1'b0);
    cfg_a = add_lit(cfg_a, 4, 1, 1'b1);
    load(cfg_a, CW, 1'b1);
    sweep(cfg_a, "R2 R10 hand map");
    for (int v = 1; v < (1 << NI); v += 2) begin
      @(negedge clk);
      in_v = NI'(v);
      #1 check(sum[1] == 1'b0, "R4 conflicting literals", sum[1], 0);
    end

    // R5 only out1 group used: sum[0] never rises
    cfg_b = add_lit('0, 4, 2, 1'b1);
    load(cfg_b, CW, 1'b0);
    for (int v = 0; v < (1 << NI); v++) begin
      @(negedge clk);
      in_v = NI'(v);
      #1 check(sum[0] == 1'b0 && sum[1] == ~in_v[2], "R5 fixed grouping", sum, {~in_v[2], 1'b0});
    end

    // pseudo-random maps, exhaustive input sweep each
    lfsr = 32'hACE1_1234;
    for (int m = 0; m < 6; m++) begin
      for (int b = 0; b < CW; b++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        cfg_r[b] = (lfsr[1:0] == 2'b00);
      end
      load(cfg_r, CW, 1'b0);
      sweep(cfg_r, "R2 R5 random map");
    end

    // R7 short session after a valid map
    load(cfg_a, CW, 1'b0);
    @(negedge clk);
    in_v = 3'b001;
    #1 check(sum == model(cfg_a, 3'b001), "R7 precondition", sum, model(cfg_a, 3'b001));
    load(cfg_a, 10, 1'b0);
    for (int v = 0; v < (1 << NI); v++) begin
      @(negedge clk);
      in_v = NI'(v);
      #1 check(sum == '0, "R7 short load masks", sum, 0);
    end

    // R8 readback of cfg_a, outputs held
    load(cfg_a, CW, 1'b0);
    @(negedge clk);
    in_v = 3'b001;
    for (int k = CW - 1; k >= 0; k--) begin
      @(negedge clk);
      #1 check(rd_bit == cfg_a[k], "R8 readback bit", rd_bit, cfg_a[k]);
      check(sum == 2'b01, "R8 sums undisturbed", sum, 2'b01);
      rd_en = 1'b1;
    end
    @(negedge clk);
    rd_en = 1'b0;
    #1 check(rd_bit == cfg_a[CW-1], "R8 pointer wrap", rd_bit, cfg_a[CW-1]);
    sweep(cfg_a, "R8 map intact after readback");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule